// File: doc/BRIEF.md
# Dual-Port Shared Mailbox Memory

This block is a 2048-byte shared memory that sits between a master processor and a worker processor. Each side has its own port with an 8-bit data path and an 11-bit byte address. The storage is split into eight banks of 256 bytes. The top three address bits choose the bank and the low eight bits choose the byte inside it. Both ports may read or write in any cycle.

When both ports write the same byte in the same cycle, a fixed rule decides the result: the master's byte is stored and the worker's write is dropped. Reads are synchronous, and a read always returns the contents from before any write made in the same cycle. The read data register keeps its value while its port is idle.

Alongside the data path, the block carries a doorbell. The master pulses a raise input. This sets an interrupt line to the worker, which stays high until the worker pulses an acknowledge.

Top module: `mbox_dpram`

## Requirements
- R1: Each port addresses 2048 bytes with an 11-bit address and 8-bit data. A byte written by either port can be read back on either port.
- R2: Address bits [10:8] select one of eight 256-byte banks and bits [7:0] select the byte within that bank. The first and last byte of each bank are stored independently of the neighbouring banks.
- R3: When a port's enable is high at a clock edge, the byte at its address appears on that port's read data output after that edge. This is one cycle of latency.
- R4: While a port's enable is low, its read data output keeps its previous value, and neither the address nor the write inputs have any effect.
- R5: If both ports write the same address in the same cycle, the master's data is stored and the worker's data is discarded.
- R6: If both ports write different addresses in the same cycle, both bytes are stored.
- R7: A read on one port in the same cycle as a write to the same address on the other port returns the old byte. The new byte is returned by the next read.
- R8: A write on a port also performs a read on that port, and the read returns the byte that was stored before the write.
- R9: A raise pulse from the master sets the worker interrupt output at the next clock edge. The output stays high for as long as no acknowledge is given.
- R10: A worker acknowledge clears the interrupt output at the next clock edge. If raise and acknowledge arrive in the same cycle, the output is set.
- R11: While reset is high, both read data outputs and the interrupt output go to zero at the next edge. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| mst_en | input | 1 | Master access enable |
| mst_we | input | 1 | Master write enable (used only when mst_en is high) |
| mst_addr | input | 11 | Master byte address |
| mst_wdata | input | 8 | Master write data |
| mst_rdata | output | 8 | Master read data, registered |
| wkr_en | input | 1 | Worker access enable |
| wkr_we | input | 1 | Worker write enable (used only when wkr_en is high) |
| wkr_addr | input | 11 | Worker byte address |
| wkr_wdata | input | 8 | Worker write data |
| wkr_rdata | output | 8 | Worker read data, registered |
| mst_irq_raise | input | 1 | Master doorbell pulse |
| wkr_irq_ack | input | 1 | Worker acknowledge pulse |
| wkr_irq | output | 1 | Interrupt request to the worker, registered |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it:
- read data on either port, including the old byte in a read-during-write;
- the effect of a write or collision on a later read;
- the interrupt line after a raise or acknowledge.

The bench drives its inputs on the falling edge. A behavioural model updates at the rising edge, in the same order as the requirements: reads take the old byte, the worker write is applied unless it collides, then the master write is applied. The outputs are compared with the model on the next falling edge. Directed checks do the same: they sample on the falling edge that follows the access. The collisions cover the first and last byte of every bank, plus several hundred random pairs of accesses that share an address about a quarter of the time.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // default geometry
  localparam int unsigned MBOX_DATA_W   = 8;
  localparam int unsigned MBOX_BANK_AW  = 8;
  localparam int unsigned MBOX_BANK_CNT = 8;

  // outcome of the write arbitration in one cycle
  typedef enum logic [1:0] {
    ARB_IDLE     = 2'd0,
    ARB_SINGLE   = 2'd1,
    ARB_SPLIT    = 2'd2,
    ARB_MST_WINS = 2'd3
  } arb_res_e;

endpackage

// File: rtl/mbox_wr_arb.sv
module mbox_wr_arb
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              m_wr,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic              w_wr,
  input  logic [ADDR_W-1:0] w_addr,
  output logic              m_wr_ok,
  output logic              w_wr_ok,
  output arb_res_e          res
);

  logic same_addr;

  always_comb begin
    same_addr = (m_addr == w_addr);
    m_wr_ok   = m_wr;
    w_wr_ok   = w_wr && !(m_wr && same_addr);
    if (m_wr && w_wr) begin
      res = same_addr ? ARB_MST_WINS : ARB_SPLIT;
    end else if (m_wr || w_wr) begin
      res = ARB_SINGLE;
    end else begin
      res = ARB_IDLE;
    end
  end

endmodule

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // port b first, port a last; same-address conflicts are removed upstream
  always_ff @(posedge clk) begin
    if (b_en && b_we) begin
      mem[b_addr] <= b_wdata;
    end
    if (a_en && a_we) begin
      mem[a_addr] <= a_wdata;
    end
  end

  // read-first output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_en) begin
        a_rdata <= mem[a_addr];
      end
      if (b_en) begin
        b_rdata <= mem[b_addr];
      end
    end
  end

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq (
  input  logic clk,
  input  logic rst,
  input  logic raise,
  input  logic ack,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= raise | (irq & ~ack);
    end
  end

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W   = MBOX_DATA_W,
  parameter int unsigned BANK_AW  = MBOX_BANK_AW,
  parameter int unsigned BANK_CNT = MBOX_BANK_CNT
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    mst_en,
  input  logic                                    mst_we,
  input  logic [BANK_AW+$clog2(BANK_CNT)-1:0]     mst_addr,
  input  logic [DATA_W-1:0]                       mst_wdata,
  output logic [DATA_W-1:0]                       mst_rdata,
  input  logic                                    wkr_en,
  input  logic                                    wkr_we,
  input  logic [BANK_AW+$clog2(BANK_CNT)-1:0]     wkr_addr,
  input  logic [DATA_W-1:0]                       wkr_wdata,
  output logic [DATA_W-1:0]                       wkr_rdata,
  input  logic                                    mst_irq_raise,
  input  logic                                    wkr_irq_ack,
  output logic                                    wkr_irq
);

  localparam int unsigned BANK_BITS = $clog2(BANK_CNT);
  localparam int unsigned ADDR_W    = BANK_AW + BANK_BITS;

  logic                 m_wr_ok;
  logic                 w_wr_ok;
  arb_res_e             arb_res;
  logic [BANK_BITS-1:0] m_bank;
  logic [BANK_BITS-1:0] w_bank;
  logic [BANK_BITS-1:0] m_bank_q;
  logic [BANK_BITS-1:0] w_bank_q;
  logic [BANK_CNT-1:0]  m_bank_en;
  logic [BANK_CNT-1:0]  w_bank_en;
  logic [BANK_CNT-1:0]  m_bank_wr;
  logic [DATA_W-1:0]    m_rd_bank [BANK_CNT];
  logic [DATA_W-1:0]    w_rd_bank [BANK_CNT];

  assign m_bank = mst_addr[ADDR_W-1:BANK_AW];
  assign w_bank = wkr_addr[ADDR_W-1:BANK_AW];

  mbox_wr_arb #(
    .ADDR_W (ADDR_W)
  ) i_arb (
    .m_wr    (mst_en && mst_we),
    .m_addr  (mst_addr),
    .w_wr    (wkr_en && wkr_we),
    .w_addr  (wkr_addr),
    .m_wr_ok (m_wr_ok),
    .w_wr_ok (w_wr_ok),
    .res     (arb_res)
  );

  generate
    for (genvar g = 0; g < BANK_CNT; g++) begin : g_bank
      assign m_bank_en[g] = mst_en && (m_bank == g[BANK_BITS-1:0]);
      assign w_bank_en[g] = wkr_en && (w_bank == g[BANK_BITS-1:0]);
      assign m_bank_wr[g] = m_wr_ok && m_bank_en[g];

      mbox_bank #(
        .ADDR_W (BANK_AW),
        .DATA_W (DATA_W)
      ) i_bank (
        .clk     (clk),
        .rst     (rst),
        .a_en    (m_bank_en[g]),
        .a_we    (m_wr_ok),
        .a_addr  (mst_addr[BANK_AW-1:0]),
        .a_wdata (mst_wdata),
        .a_rdata (m_rd_bank[g]),
        .b_en    (w_bank_en[g]),
        .b_we    (w_wr_ok),
        .b_addr  (wkr_addr[BANK_AW-1:0]),
        .b_wdata (wkr_wdata),
        .b_rdata (w_rd_bank[g])
      );
    end
  endgenerate

  // remember which bank produced the last read on each port
  always_ff @(posedge clk) begin
    if (rst) begin
      m_bank_q <= '0;
      w_bank_q <= '0;
    end else begin
      if (mst_en) begin
        m_bank_q <= m_bank;
      end
      if (wkr_en) begin
        w_bank_q <= w_bank;
      end
    end
  end

  assign mst_rdata = m_rd_bank[m_bank_q];
  assign wkr_rdata = w_rd_bank[w_bank_q];

  mbox_irq i_irq (
    .clk   (clk),
    .rst   (rst),
    .raise (mst_irq_raise),
    .ack   (wkr_irq_ack),
    .irq   (wkr_irq)
  );

endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned BANK_CNT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mst_en,
  input logic              mst_we,
  input logic [ADDR_W-1:0] mst_addr,
  input logic [DATA_W-1:0] mst_rdata,
  input logic              wkr_en,
  input logic              wkr_we,
  input logic [ADDR_W-1:0] wkr_addr,
  input logic [DATA_W-1:0] wkr_rdata,
  input logic              mst_irq_raise,
  input logic              wkr_irq_ack,
  input logic              wkr_irq,
  input logic              w_wr_ok,
  input logic [BANK_CNT-1:0] m_bank_wr,
  input arb_res_e          arb_res
);

  // R5
  worker_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mst_en && mst_we && wkr_en && wkr_we && mst_addr == wkr_addr)
      |-> (!w_wr_ok && arb_res == ARB_MST_WINS));

  // R2
  bank_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_bank_wr));

  // R4
  m_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mst_en |=> $stable(mst_rdata));

  // R4
  w_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wkr_en |=> $stable(wkr_rdata));

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    mst_irq_raise |=> wkr_irq);

  // R9
  irq_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wkr_irq && !wkr_irq_ack) |=> wkr_irq);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wkr_irq_ack && !mst_irq_raise) |=> !wkr_irq);

  // R11
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (!wkr_irq && mst_rdata == '0 && wkr_rdata == '0));

endmodule

bind mbox_dpram mbox_dpram_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .BANK_CNT (BANK_CNT)
) i_chk (
  .clk           (clk),
  .rst           (rst),
  .mst_en        (mst_en),
  .mst_we        (mst_we),
  .mst_addr      (mst_addr),
  .mst_rdata     (mst_rdata),
  .wkr_en        (wkr_en),
  .wkr_we        (wkr_we),
  .wkr_addr      (wkr_addr),
  .wkr_rdata     (wkr_rdata),
  .mst_irq_raise (mst_irq_raise),
  .wkr_irq_ack   (wkr_irq_ack),
  .wkr_irq       (wkr_irq),
  .w_wr_ok       (w_wr_ok),
  .m_bank_wr     (m_bank_wr),
  .arb_res       (arb_res)
);

// File: tb/test_mbox_dpram.sv
module test_mbox_dpram;

  logic        clk = 1'b0;
  logic        rst;
  logic        mst_en, mst_we, wkr_en, wkr_we;
  logic [10:0] mst_addr, wkr_addr;
  logic [7:0]  mst_wdata, wkr_wdata;
  logic [7:0]  mst_rdata, wkr_rdata;
  logic        mst_irq_raise, wkr_irq_ack, wkr_irq;

  int n_chk  = 0;
  int n_fail = 0;
  int n_cyc  = 0;
  string cur_req = "R11";

  // reference model state
  logic [7:0] ref_mem   [2048];
  bit         ref_known [2048];
  logic [7:0] exp_m, exp_w;
  bit         exp_m_ok, exp_w_ok;
  logic       exp_irq;
  bit         started = 1'b0;

  always #5 clk = ~clk;

  mbox_dpram i_mbox_dpram (
    .clk           (clk),
    .rst           (rst),
    .mst_en        (mst_en),
    .mst_we        (mst_we),
    .mst_addr      (mst_addr),
    .mst_wdata     (mst_wdata),
    .mst_rdata     (mst_rdata),
    .wkr_en        (wkr_en),
    .wkr_we        (wkr_we),
    .wkr_addr      (wkr_addr),
    .wkr_wdata     (wkr_wdata),
    .wkr_rdata     (wkr_rdata),
    .mst_irq_raise (mst_irq_raise),
    .wkr_irq_ack   (wkr_irq_ack),
    .wkr_irq       (wkr_irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural model: old reads, worker write unless overruled, master write
  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      exp_m = 8'h00; exp_m_ok = 1'b1;
      exp_w = 8'h00; exp_w_ok = 1'b1;
      exp_irq = 1'b0;
    end else begin
      if (mst_en) begin
        exp_m = ref_mem[mst_addr]; exp_m_ok = ref_known[mst_addr];
      end
      if (wkr_en) begin
        exp_w = ref_mem[wkr_addr]; exp_w_ok = ref_known[wkr_addr];
      end
      if (wkr_en && wkr_we && !(mst_en && mst_we && mst_addr == wkr_addr)) begin
        ref_mem[wkr_addr] = wkr_wdata; ref_known[wkr_addr] = 1'b1;
      end
      if (mst_en && mst_we) begin
        ref_mem[mst_addr] = mst_wdata; ref_known[mst_addr] = 1'b1;
      end
      exp_irq = mst_irq_raise | (exp_irq & ~wkr_irq_ack);
    end
  end

  // per-cycle comparison away from the rising edge
  always @(negedge clk) begin
    if (started) begin
      if (exp_m_ok) chk(cur_req, "mst_rdata", mst_rdata, exp_m);
      if (exp_w_ok) chk(cur_req, "wkr_rdata", wkr_rdata, exp_w);
      chk(cur_req, "wkr_irq", {7'd0, wkr_irq}, {7'd0, exp_irq});
    end
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 60000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=60000", n_cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step(input logic me, input logic mw, input logic [10:0] ma,
                      input logic [7:0] md, input logic we_, input logic ww,
                      input logic [10:0] wa, input logic [7:0] wd,
                      input logic rs, input logic ak);
    mst_en = me; mst_we = mw; mst_addr = ma; mst_wdata = md;
    wkr_en = we_; wkr_we = ww; wkr_addr = wa; wkr_wdata = wd;
    mst_irq_raise = rs; wkr_irq_ack = ak;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 11'd0, 8'd0, 0, 0, 11'd0, 8'd0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) ref_known[i] = 1'b0;
    rst = 1'b1;
    mst_en = 0; mst_we = 0; mst_addr = '0; mst_wdata = '0;
    wkr_en = 0; wkr_we = 0; wkr_addr = '0; wkr_wdata = '0;
    mst_irq_raise = 0; wkr_irq_ack = 0;
    repeat (3) @(negedge clk);
    // R11: outputs cleared by reset
    chk("R11", "mst_rdata after reset", mst_rdata, 8'h00);
    chk("R11", "wkr_rdata after reset", wkr_rdata, 8'h00);
    chk("R11", "wkr_irq after reset", {7'd0, wkr_irq}, 8'h00);
    rst = 1'b0;

    // R1: fill through the master, read back through both ports
    cur_req = "R1";
    for (int i = 0; i < 2048; i++) step(1, 1, 11'(i), 8'(i * 7 + 3), 0, 0, 11'd0, 8'd0, 0, 0);
    cur_req = "R3";
    for (int i = 0; i < 2048; i++) step(1, 0, 11'(2047 - i), 8'd0, 1, 0, 11'(i), 8'd0, 0, 0);
    chk("R3", "wkr read of 0x7FF", wkr_rdata, 8'(2047 * 7 + 3));

    // R2/R5: collisions on the first and last byte of every bank
    cur_req = "R2";
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 2; k++) begin
        logic [10:0] a;
        a = 11'(b * 256 + k * 255);
        step(1, 1, a, 8'(a) ^ 8'h5C, 1, 1, a, ~(8'(a) ^ 8'h5C), 0, 0);
        step(1, 0, a, 8'd0, 1, 0, a, 8'd0, 0, 0);
        chk("R5", "master wins at bank edge (mst)", mst_rdata, 8'(a) ^ 8'h5C);
        chk("R5", "master wins at bank edge (wkr)", wkr_rdata, 8'(a) ^ 8'h5C);
      end
      if (b > 0) begin
        step(1, 0, 11'(b * 256 - 1), 8'd0, 1, 0, 11'(b * 256), 8'd0, 0, 0);
        chk("R2", "bank end byte", mst_rdata, 8'(11'(b * 256 - 1)) ^ 8'h5C);
        chk("R2", "bank start byte", wkr_rdata, 8'(11'(b * 256)) ^ 8'h5C);
      end
    end

    // R5 directed
    cur_req = "R5";
    step(1, 1, 11'h100, 8'hA5, 1, 1, 11'h100, 8'h5A, 0, 0);
    step(1, 0, 11'h100, 8'd0, 1, 0, 11'h100, 8'd0, 0, 0);
    chk("R5", "collision stored master byte", wkr_rdata, 8'hA5);

    // R6 distinct simultaneous writes
    cur_req = "R6";
    step(1, 1, 11'h200, 8'h12, 1, 1, 11'h201, 8'h34, 0, 0);
    step(1, 0, 11'h201, 8'd0, 1, 0, 11'h200, 8'd0, 0, 0);
    chk("R6", "worker byte kept", mst_rdata, 8'h34);
    chk("R6", "master byte kept", wkr_rdata, 8'h12);

    // R7 read during write on the other port
    cur_req = "R7";
    step(1, 1, 11'h7FF, 8'h11, 0, 0, 11'd0, 8'd0, 0, 0);
    step(1, 0, 11'h7FF, 8'd0, 1, 1, 11'h7FF, 8'h3C, 0, 0);
    chk("R7", "old byte on master read", mst_rdata, 8'h11);
    step(1, 0, 11'h7FF, 8'd0, 0, 0, 11'd0, 8'd0, 0, 0);
    chk("R7", "new byte next read", mst_rdata, 8'h3C);

    // R8 read-first on the writing port: 0x0AA holds (170*7+3)&0xFF = 0xA9
    cur_req = "R8";
    step(1, 1, 11'h0AA, 8'h77, 0, 0, 11'd0, 8'd0, 0, 0);
    chk("R8", "old byte on write", mst_rdata, 8'hA9);

    // R4 idle port holds, idle inputs ignored
    cur_req = "R4";
    step(1, 0, 11'h200, 8'd0, 0, 0, 11'd0, 8'd0, 0, 0);
    step(0, 1, 11'h201, 8'hEE, 0, 1, 11'h200, 8'hDD, 0, 0);
    chk("R4", "held rdata", mst_rdata, 8'h12);
    step(1, 0, 11'h201, 8'd0, 1, 0, 11'h200, 8'd0, 0, 0);
    chk("R4", "no write while disabled (mst)", mst_rdata, 8'h34);
    chk("R4", "no write while disabled (wkr)", wkr_rdata, 8'h12);

    // random traffic with frequent collisions
    cur_req = "R5";
    for (int i = 0; i < 600; i++) begin
      logic [10:0] ma, wa;
      ma = 11'($urandom % 2048);
      wa = ($urandom % 4 == 0) ? ma : 11'($urandom % 2048);
      step(1'($urandom), 1'($urandom), ma, 8'($urandom),
           1'($urandom), 1'($urandom), wa, 8'($urandom), 0, 0);
    end

    // R9/R10 interrupt handshake
    cur_req = "R9";
    idle();
    step(0, 0, 11'd0, 8'd0, 0, 0, 11'd0, 8'd0, 1, 0);
    chk("R9", "irq set", {7'd0, wkr_irq}, 8'h01);
    idle(); idle(); idle();
    chk("R9", "irq held", {7'd0, wkr_irq}, 8'h01);
    cur_req = "R10";
    step(0, 0, 11'd0, 8'd0, 0, 0, 11'd0, 8'd0, 0, 1);
    chk("R10", "irq cleared", {7'd0, wkr_irq}, 8'h00);
    step(0, 0, 11'd0, 8'd0, 0, 0, 11'd0, 8'd0, 1, 0);
    step(0, 0, 11'd0, 8'd0, 0, 0, 11'd0, 8'd0, 1, 1);
    chk("R10", "raise wins over ack", {7'd0, wkr_irq}, 8'h01);
    step(0, 0, 11'd0, 8'd0, 0, 0, 11'd0, 8'd0, 0, 1);
    chk("R10", "irq cleared again", {7'd0, wkr_irq}, 8'h00);
    idle();

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule